// File: doc/BRIEF.md
# Masked Scan Response Checker

This block sits at the end of one response wire of the test access mechanism and judges a core's scan-out stream on chip. Each beat carries produced response bits from the core's wrapper chain together with golden bits and care bits that a separate output decoder delivers in lock step. Only positions whose care bit is set are compared. Positions whose care bit is clear are skipped, so unknown values in the response never cause a failure.

A mismatch is reported at once. A one-cycle pulse is raised and a sticky failure flag is set, so the tester can abort at the first faulty bit instead of waiting for a signature at the end of the test. The block also records the stream position of that first faulty bit for diagnosis. When several cores receive the same broadcast stimulus, each core gets its own instance on its own response wire. A synchronous clear starts every test. An end-of-test strobe closes the test and yields a done and pass verdict.

The beat width `LANES` is a parameter. Lane 0 carries the earliest bit of a beat.

Top module: `masked_resp_cmp`

## Requirements
- R1: After reset, fail_o, fail_pulse_o, done_o and pass_o are 0 and fail_index_o is 0.
- R2: On a beat with beat_valid_i high, any lane whose care bit is 1 and whose response bit differs from its golden bit sets fail_o in the next cycle.
- R3: A lane whose care bit is 0 never causes a failure, whatever its response bit holds, including an unknown value.
- R4: When beat_valid_i is low, no comparison is made and the bit position does not advance.
- R5: fail_pulse_o is high for exactly one cycle, in the same cycle that fail_o first rises. Later mismatches in the same test give no further pulse.
- R6: Once set, fail_o stays high until a clear.
- R7: fail_index_o equals the number of bits compared before the first failing bit. Each valid beat counts LANES bits, and within a beat the lowest failing lane counts first. The value holds still after the failure.
- R8: eot_i sets done_o in the next cycle. pass_o is done_o and not fail_o. A failure in the same beat as eot_i leaves pass_o at 0.
- R9: clr_i returns all outputs to their reset values in the next cycle and takes priority over a beat or eot_i in the same cycle.
- R10: After done_o is set, valid beats are ignored until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear at the start of a test |
| beat_valid_i | input | 1 | Marks a beat to compare |
| resp_i | input | LANES | Produced response bits, lane 0 earliest |
| gold_i | input | LANES | Expected response bits |
| care_i | input | LANES | 1 means compare this lane, 0 means skip it |
| eot_i | input | 1 | End-of-test strobe |
| fail_o | output | 1 | Sticky failure flag |
| fail_pulse_o | output | 1 | One-cycle marker of the first failure |
| fail_index_o | output | IDX_W | Stream position of the first failing bit |
| done_o | output | 1 | Test closed |
| pass_o | output | 1 | Test closed with no failure |

## Verification
A two-lane instance is swept over all 64 combinations of response, golden and care bits in a single beat. This separates masked from unmasked mismatches and shows which lane the index picks when both lanes fail. Runs of clean beats of varying length, followed by a failure in either lane, check that the index counts only valid beats. Idle beats that carry mismatching data show that no comparison happens without beat_valid_i. Further sequences check that end of test yields pass or fail, that a clear wins over a beat in the same cycle, and that mismatches after a failure or after done_o change nothing.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;
   localparam int unsigned RCMP_IDX_W_DEF = 32;

   typedef struct packed {
      logic fail;
      logic pulse;
      logic done;
   } rcmp_flags_t;

   localparam rcmp_flags_t RCMP_FLAGS_IDLE = '{fail: 1'b0, pulse: 1'b0, done: 1'b0};
endpackage

// File: rtl/rcmp_lane.sv
module rcmp_lane (
   input  logic resp_i,
   input  logic gold_i,
   input  logic care_i,
   output logic miss_o
);
   // a cleared care bit forces 0 even when resp_i is unknown
   always_comb miss_o = care_i & (resp_i ^ gold_i);
endmodule

// File: rtl/rcmp_first.sv
module rcmp_first #(
   parameter int unsigned LANES = 1,
   localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0] miss_i,
   output logic             any_o,
   output logic [LW-1:0]    lane_o
);
   generate
      if (LANES == 1) begin : g_single
         always_comb begin
            any_o  = miss_i[0];
            lane_o = '0;
         end
      end else begin : g_multi
         always_comb begin
            any_o  = |miss_i;
            lane_o = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
               if (miss_i[i]) lane_o = LW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rcmp_track.sv
module rcmp_track
   import rcmp_pkg::*;
#(
   parameter int unsigned LANES = 1,
   parameter int unsigned IDX_W = RCMP_IDX_W_DEF,
   localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             beat_i,
   input  logic             hit_i,
   input  logic [LW-1:0]    hit_lane_i,
   input  logic             eot_i,
   output logic             fail_o,
   output logic             fail_pulse_o,
   output logic             done_o,
   output logic [IDX_W-1:0] fail_index_o
);
   rcmp_flags_t      flags_q;
   logic [IDX_W-1:0] pos_q;
   logic [IDX_W-1:0] idx_q;
   logic             live;

   always_comb live = beat_i & ~flags_q.fail & ~flags_q.done & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= RCMP_FLAGS_IDLE;
         pos_q   <= '0;
         idx_q   <= '0;
      end else if (clr_i) begin
         flags_q <= RCMP_FLAGS_IDLE;
         pos_q   <= '0;
         idx_q   <= '0;
      end else begin
         flags_q.pulse <= 1'b0;
         if (live) begin
            pos_q <= pos_q + IDX_W'(LANES);
            if (hit_i) begin
               flags_q.fail  <= 1'b1;
               flags_q.pulse <= 1'b1;
               idx_q         <= pos_q + IDX_W'(hit_lane_i);
            end
         end
         if (eot_i) flags_q.done <= 1'b1;
      end
   end

   always_comb begin
      fail_o       = flags_q.fail;
      fail_pulse_o = flags_q.pulse;
      done_o       = flags_q.done;
      fail_index_o = idx_q;
   end

   // R5
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.pulse |=> !flags_q.pulse);
   // R5
   pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q.fail) |-> flags_q.pulse);
   // R6
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.fail && !clr_i |=> flags_q.fail);
   // R7
   index_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.fail && !clr_i |=> $stable(idx_q));
   // R9
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flags_q.fail && !flags_q.done && !flags_q.pulse);
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_i && !clr_i |=> $stable(pos_q));
endmodule

// File: rtl/masked_resp_cmp.sv
module masked_resp_cmp
   import rcmp_pkg::*;
#(
   parameter int unsigned LANES = 1,
   parameter int unsigned IDX_W = RCMP_IDX_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             beat_valid_i,
   input  logic [LANES-1:0] resp_i,
   input  logic [LANES-1:0] gold_i,
   input  logic [LANES-1:0] care_i,
   input  logic             eot_i,
   output logic             fail_o,
   output logic             fail_pulse_o,
   output logic [IDX_W-1:0] fail_index_o,
   output logic             done_o,
   output logic             pass_o
);
   localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("masked_resp_cmp: LANES must be at least 1");
      end
      if (IDX_W < LW + 1) begin : g_bad_idx
         $error("masked_resp_cmp: IDX_W too narrow for LANES");
      end
   endgenerate

   logic [LANES-1:0] miss;
   logic             hit;
   logic [LW-1:0]    hit_lane;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         rcmp_lane u_lane (
            .resp_i (resp_i[g]),
            .gold_i (gold_i[g]),
            .care_i (care_i[g]),
            .miss_o (miss[g])
         );
      end
   endgenerate

   rcmp_first #(.LANES(LANES)) u_first (
      .miss_i (miss),
      .any_o  (hit),
      .lane_o (hit_lane)
   );

   rcmp_track #(.LANES(LANES), .IDX_W(IDX_W)) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr_i),
      .beat_i       (beat_valid_i),
      .hit_i        (hit),
      .hit_lane_i   (hit_lane),
      .eot_i        (eot_i),
      .fail_o       (fail_o),
      .fail_pulse_o (fail_pulse_o),
      .done_o       (done_o),
      .fail_index_o (fail_index_o)
   );

   always_comb pass_o = done_o & ~fail_o;

   // R3
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid_i && (care_i == '0) && !fail_o |=> !fail_o);
   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid_i && !fail_o |=> !fail_o);
   // R8
   pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o && !fail_o);
   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !clr_i |=> done_o && ($past(fail_o) == fail_o));
endmodule

// File: tb/masked_resp_cmp_test.sv
module masked_resp_cmp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr, v, eot;
   logic [1:0]  r, e, c;
   logic        fail, pulse, done, pass;
   logic [31:0] fidx;
   int          checks = 0;
   int          failures = 0;

   always #10 clk = ~clk;

   masked_resp_cmp #(.LANES(2), .IDX_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .beat_valid_i(v),
      .resp_i(r), .gold_i(e), .care_i(c), .eot_i(eot),
      .fail_o(fail), .fail_pulse_o(pulse), .fail_index_o(fidx),
      .done_o(done), .pass_o(pass)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic beat(input logic cl, input logic vv, input logic et,
                       input logic [1:0] rr, input logic [1:0] ee, input logic [1:0] cc);
      @(negedge clk);
      clr = cl; v = vv; eot = et; r = rr; e = ee; c = cc;
      @(posedge clk);
      #5;
      clr = 0; v = 0; eot = 0; r = 0; e = 0; c = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      clr = 0; v = 0; eot = 0; r = 0; e = 0; c = 0;
      repeat (3) @(posedge clk);
      #5;
      chk("R1 fail", fail, 0); chk("R1 pulse", pulse, 0);
      chk("R1 done", done, 0); chk("R1 pass", pass, 0); chk("R1 index", fidx, 0);
      rst_n = 1'b1;

      // R2 R3 R7: every single-beat combination of two lanes
      for (int k = 0; k < 64; k++) begin
         logic [1:0] rr, ee, cc, mm;
         rr = k[1:0]; ee = k[3:2]; cc = k[5:4];
         mm = cc & (rr ^ ee);
         beat(1, 0, 0, 0, 0, 0);
         beat(0, 1, 0, rr, ee, cc);
         chk("R2 fail", fail, 32'(|mm));
         chk("R5 pulse", pulse, 32'(|mm));
         chk("R7 lane index", fidx, mm[0] ? 0 : (mm[1] ? 1 : 0));
      end

      // R3: unknown response on masked lanes
      beat(1, 0, 0, 0, 0, 0);
      beat(0, 1, 0, 2'bxx, 2'b11, 2'b00);
      chk("R3 unknown masked", fail, 0);

      // R7: clean runs of length n, then failure in lane j
      for (int n = 0; n < 6; n++) begin
         for (int j = 0; j < 2; j++) begin
            beat(1, 0, 0, 0, 0, 0);
            for (int b = 0; b < n; b++) beat(0, 1, 0, 2'b10, 2'b10, 2'b11);
            beat(0, 1, 0, (j == 0) ? 2'b01 : 2'b10, 2'b00, 2'b11);
            chk("R7 run index", fidx, 2 * n + j);
         end
      end

      // R4: idle beats with mismatching data
      beat(1, 0, 0, 0, 0, 0);
      beat(0, 0, 0, 2'b11, 2'b00, 2'b11);
      chk("R4 idle no fail", fail, 0);
      beat(0, 1, 0, 0, 0, 2'b11);
      beat(0, 0, 0, 2'b11, 2'b00, 2'b11);
      beat(0, 1, 0, 2'b10, 2'b00, 2'b11);
      chk("R4 index skips idle", fidx, 3);

      // R5 R6 R7: later mismatch after failure
      beat(0, 0, 0, 0, 0, 0);
      chk("R5 pulse one cycle", pulse, 0);
      beat(0, 1, 0, 2'b01, 2'b00, 2'b11);
      chk("R5 no second pulse", pulse, 0);
      chk("R6 sticky", fail, 1);
      chk("R7 frozen", fidx, 3);
      repeat (3) beat(0, 0, 0, 0, 0, 0);
      chk("R6 sticky idle", fail, 1);

      // R8 pass path and R10
      beat(1, 0, 0, 0, 0, 0);
      beat(0, 1, 0, 2'b01, 2'b01, 2'b11);
      chk("R8 not done yet", done, 0);
      beat(0, 1, 1, 2'b11, 2'b11, 2'b11);
      chk("R8 done", done, 1);
      chk("R8 pass", pass, 1);
      beat(0, 1, 0, 2'b11, 2'b00, 2'b11);
      chk("R10 ignored fail", fail, 0);
      chk("R10 still pass", pass, 1);

      // R8 failure in same beat as end of test
      beat(1, 0, 0, 0, 0, 0);
      beat(0, 1, 1, 2'b00, 2'b10, 2'b10);
      chk("R8 done on fail", done, 1);
      chk("R8 pass low", pass, 0);
      chk("R8 fail", fail, 1);

      // R9 clear wins over beat and end of test
      beat(1, 1, 1, 2'b11, 2'b00, 2'b11);
      chk("R9 fail cleared", fail, 0);
      chk("R9 done cleared", done, 0);
      chk("R9 pulse low", pulse, 0);
      chk("R9 index cleared", fidx, 0);
      beat(0, 1, 0, 2'b00, 2'b01, 2'b01);
      chk("R9 fresh count", fidx, 0);
      chk("R2 after clear", fail, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule